// File: doc/BRIEF.md
# Prioritized Service-Acknowledge Controller

This block collects service requests from the channels of a multi-channel peripheral and turns them into acknowledge responses and a service context for the CPU. Each channel can raise four kinds of request: receive, transmit, parallel port and modem. For each kind there is a service-request output that stays high while any channel has that kind of request pending. When the CPU runs an acknowledge read cycle, the block picks one pending request and returns an 8-bit vector. The vector carries the request kind and a five-bit code taken from the chosen channel's local vector register. The code can hold the channel number on its own, or the channel number together with a chip number.

After a successful acknowledge, the block holds a service context. While the context is open, the CPU can read the kind and channel being served, the receive level of that channel, and the receive data, where each data read pops the external FIFO once. The context closes only when the CPU writes any value to the end-of-service address. The CPU can also open the same context by a register write, with no acknowledge cycle at all.

Top module: `prio_ack_ctrl`

## Requirements
- R1: `srq[t]` is high exactly when some channel has request kind `t` pending. Kind index 0 is receive, 1 transmit, 2 parallel, 3 modem. The one exception is the kind that is being served (R7).
- R2: An acknowledge (`ack_rd` high) considers only the kinds whose `ack_sel` bit is set. Among those kinds, it serves receive first, then transmit, then parallel, then modem. With all `ack_sel` bits set this is the common-acknowledge case.
- R3: Within the winning kind, the lowest-numbered pending channel is served.
- R4: The cycle after an acknowledge, `ack_vec` holds `{code[4:0], 1'b1, kind[1:0]}`, with kind 00 receive, 01 transmit, 10 parallel, 11 modem. When no selected request is pending, `ack_vec` is 8'h00 instead. `ack_vec` is 8'h00 in every cycle that does not follow an acknowledge.
- R5: Each channel's five-bit code resets to `(CHIP_ID << log2(NCH)) + channel`. A write to address 8+ch loads `cpu_wdata[4:0]` into channel ch's code, and a read of that address returns the code zero-extended. Acknowledge vectors use the code as it currently stands.
- R6: An acknowledge that arrives while a context is open returns 8'h00 and leaves the kind and channel of the context unchanged.
- R7: While a context of kind `t` is open, `srq[t]` is low even if kind `t` is still requested. It comes back after end-of-service if the request is still present.
- R8: A read of address 0 returns `{open, 1'b0, kind[1:0], 1'b0, channel[2:0]}`. It returns 8'h00 when no context is open. Read data appears on `cpu_rdata` the cycle after `cpu_rd`, and is 0 in cycles that do not follow a read.
- R9: During a context, address 1 returns the receive level of the context channel. During a receive context, a read of address 2 returns `rx_fifo_data`, and in that same cycle `rx_pop` pulses with `rx_pop_ch` set to the channel. In any other state, address 2 returns 0 and `rx_pop` stays low.
- R10: A write of any value to address 3 closes the context in the next cycle.
- R11: When no context is open, a write to address 4 opens one with kind `cpu_wdata[7:6]` and channel `cpu_wdata[2:0]`. While a context is open, such a write has no effect. An acknowledge in the same cycle takes precedence over this write.
- R12: Addresses 5, 6 and 7 return `{1'b1, 4'b0, channel[2:0]}` during a receive, transmit or modem context respectively. In all other cases they return 0.
- R13: After reset there is no context, and `ack_vec` and `cpu_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rx | input | NCH | Receive request per channel |
| req_tx | input | NCH | Transmit request per channel |
| req_par | input | NCH | Parallel-port request per channel |
| req_mdm | input | NCH | Modem request per channel |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_sel | input | 4 | Kinds this acknowledge may serve (all ones for common acknowledge) |
| ack_vec | output | 8 | Registered acknowledge vector |
| srq | output | 4 | Service request per kind |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| rx_lvl | input | NCH*LVLW | Receive FIFO level per channel |
| rx_fifo_data | input | 8 | Head of the selected receive FIFO |
| rx_pop | output | 1 | Pop pulse for the receive FIFO |
| rx_pop_ch | output | CHW | Channel to pop |

## Verification
The acknowledge path is driven with a table of request patterns. Some rows have several kinds pending at once, which shows whether kind priority beats channel number. Some rows have several channels pending within one kind, which isolates the lowest-channel rule. Rows with a partial `ack_sel` show that unselected kinds are skipped. Rows with empty or unselected requests must produce the null vector. Directed sequences then serve a receive-plus-parallel pair in two rounds, send acknowledges into an open context, and enter the context by software. They also pop the FIFO in receive and non-receive contexts, which separates context gating from plain address decoding.

// File: rtl/prio_ack_ctrl.sv
module prio_ack_ctrl #(
  parameter int NCH     = 4,
  parameter int CHIP_ID = 5,
  parameter int LVLW    = 8,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req_rx,
  input  logic [NCH-1:0]        req_tx,
  input  logic [NCH-1:0]        req_par,
  input  logic [NCH-1:0]        req_mdm,
  input  logic                  ack_rd,
  input  logic [3:0]            ack_sel,
  output logic [7:0]            ack_vec,
  output logic [3:0]            srq,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [3:0]            cpu_addr,
  input  logic [7:0]            cpu_wdata,
  output logic [7:0]            cpu_rdata,
  input  logic [NCH*LVLW-1:0]   rx_lvl,
  input  logic [7:0]            rx_fifo_data,
  output logic                  rx_pop,
  output logic [CHW-1:0]        rx_pop_ch
);

  logic [3:0][NCH-1:0] rq;
  logic [4:0]          lvec [NCH];
  logic                act;
  logic [1:0]          ctype;
  logic [CHW-1:0]      cch;
  logic                win;
  logic [1:0]          wt;
  logic [CHW-1:0]      wc;
  logic                ack_hit, sw_ent, eos;
  logic [7:0]          rd_mux;

  assign rq = {req_mdm, req_par, req_tx, req_rx};

  function automatic logic [CHW-1:0] low_idx(input logic [NCH-1:0] v);
    low_idx = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (v[i]) low_idx = CHW'(i);
  endfunction

  always_comb begin
    win = 1'b0;
    wt  = 2'd0;
    wc  = '0;
    for (int t = 3; t >= 0; t--)
      if (ack_sel[t] && |rq[t]) begin
        win = 1'b1;
        wt  = 2'(t);
        wc  = low_idx(rq[t]);
      end
  end

  always_comb
    for (int t = 0; t < 4; t++)
      srq[t] = |rq[t] && !(act && ctype == 2'(t));

  assign ack_hit   = ack_rd && !act && win;
  assign sw_ent    = cpu_wr && cpu_addr == 4'd4 && !act;
  assign eos       = cpu_wr && cpu_addr == 4'd3;
  assign rx_pop    = cpu_rd && cpu_addr == 4'd2 && act && ctype == 2'd0;
  assign rx_pop_ch = cch;

  always_comb begin
    rd_mux = 8'h00;
    case (cpu_addr)
      4'd0: rd_mux = act ? {1'b1, 1'b0, ctype, 1'b0, 3'(cch)} : 8'h00;
      4'd1: rd_mux = act ? 8'(rx_lvl[cch*LVLW +: LVLW]) : 8'h00;
      4'd2: rd_mux = rx_pop ? rx_fifo_data : 8'h00;
      4'd5: rd_mux = (act && ctype == 2'd0) ? {5'b10000, 3'(cch)} : 8'h00;
      4'd6: rd_mux = (act && ctype == 2'd1) ? {5'b10000, 3'(cch)} : 8'h00;
      4'd7: rd_mux = (act && ctype == 2'd3) ? {5'b10000, 3'(cch)} : 8'h00;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (cpu_addr == 4'(8 + i)) rd_mux = {3'b000, lvec[i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      ctype     <= 2'd0;
      cch       <= '0;
      ack_vec   <= 8'h00;
      cpu_rdata <= 8'h00;
      for (int i = 0; i < NCH; i++) lvec[i] <= 5'((CHIP_ID << CHW) + i);
    end else begin
      ack_vec   <= ack_hit ? {lvec[wc], 1'b1, wt} : 8'h00;
      cpu_rdata <= cpu_rd ? rd_mux : 8'h00;
      if (ack_hit) begin
        act   <= 1'b1;
        ctype <= wt;
        cch   <= wc;
      end else if (sw_ent) begin
        act   <= 1'b1;
        ctype <= cpu_wdata[7:6];
        cch   <= cpu_wdata[CHW-1:0];
      end else if (eos) begin
        act   <= 1'b0;
      end
      for (int i = 0; i < NCH; i++)
        if (cpu_wr && cpu_addr == 4'(8 + i)) lvec[i] <= cpu_wdata[4:0];
    end
  end

endmodule

// File: rtl/prio_ack_chk.sv
module prio_ack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_rd,
  input logic [7:0] ack_vec,
  input logic [3:0] srq,
  input logic       act,
  input logic [1:0] ctype,
  input logic       cpu_wr,
  input logic [3:0] cpu_addr
);

  p_busy_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act && ack_rd |=> ack_vec == 8'h00 && act && $stable(ctype));

  p_vec_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec[2] |-> act);

  p_vec_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec[2] |=> !ack_vec[2]);

  p_idle_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd |=> ack_vec == 8'h00);

  p_srq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !srq[ctype]);

  p_eos_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act && cpu_wr && cpu_addr == 4'd3 |=> !act);

endmodule

bind prio_ack_ctrl prio_ack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .ack_vec(ack_vec), .srq(srq),
  .act(act), .ctype(ctype), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr)
);

// File: tb/prio_ack_ctrl_bench.sv
`timescale 1ns/1ps
module prio_ack_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_rx = '0, req_tx = '0, req_par = '0, req_mdm = '0;
  logic       ack_rd = 1'b0;
  logic [3:0] ack_sel = '0;
  logic [7:0] ack_vec;
  logic [3:0] srq;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [31:0] rx_lvl = '0;
  logic [7:0] rx_fifo_data = '0;
  logic       rx_pop;
  logic [1:0] rx_pop_ch;

  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  prio_ack_ctrl u_prio_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .req_rx(req_rx), .req_tx(req_tx), .req_par(req_par),
    .req_mdm(req_mdm), .ack_rd(ack_rd), .ack_sel(ack_sel), .ack_vec(ack_vec), .srq(srq),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rx_lvl(rx_lvl), .rx_fifo_data(rx_fifo_data),
    .rx_pop(rx_pop), .rx_pop_ch(rx_pop_ch)
  );

  // {ack_sel, rx, tx, par, mdm, expected vector}; code = {3'b101, ch}
  localparam int NV = 9;
  localparam logic [27:0] VT [NV] = '{
    {4'hF, 4'b0010, 4'b0001, 4'b0000, 4'b0000, 8'hAC},
    {4'hF, 4'b0000, 4'b0000, 4'b0100, 4'b0001, 8'hB6},
    {4'hF, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 8'hBC},
    {4'hF, 4'b0000, 4'b0000, 4'b0000, 4'b1010, 8'hAF},
    {4'h2, 4'b1111, 4'b0100, 4'b0000, 4'b0000, 8'hB5},
    {4'h8, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 8'h00},
    {4'hF, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'h00},
    {4'hC, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 8'hA6},
    {4'hF, 4'b0000, 4'b1100, 4'b0001, 4'b0000, 8'hB5}
  };

  task automatic chk(input logic [7:0] act_v, input logic [7:0] exp_v, input string req);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic do_ack(input logic [3:0] sel);
    @(negedge clk); ack_sel = sel; ack_rd = 1'b1;
    @(negedge clk); ack_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic set_req(input logic [3:0] r, t, p, m);
    req_rx = r; req_tx = t; req_par = p; req_mdm = m;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack_vec, 8'h00, "R13 vector at reset");
    chk(cpu_rdata, 8'h00, "R13 rdata at reset");
    rd(4'd0, rv); chk(rv, 8'h00, "R13 no context");

    for (int i = 0; i < NV; i++) begin
      set_req(VT[i][23:20], VT[i][19:16], VT[i][15:12], VT[i][11:8]);
      do_ack(VT[i][27:24]);
      chk(ack_vec, VT[i][7:0], $sformatf("R2 R3 R4 table row %0d", i));
      @(negedge clk);
      chk(ack_vec, 8'h00, "R4 vector lasts one cycle");
      wr(4'd3, 8'h00);
      set_req(4'b0, 4'b0, 4'b0, 4'b0);
    end

    set_req(4'b0100, 4'b0000, 4'b0000, 4'b0001);
    #1 chk({4'b0, srq}, 8'h09, "R1 srq per kind");

    set_req(4'b0001, 4'b0000, 4'b0001, 4'b0000);
    do_ack(4'hF);
    chk(ack_vec, 8'hA4, "R2 receive before parallel");
    #1 chk({4'b0, srq}, 8'h04, "R7 receive srq masked");
    do_ack(4'hF);
    chk(ack_vec, 8'h00, "R6 ack during context null");
    rd(4'd0, rv); chk(rv, 8'h80, "R6 R8 context unchanged");
    wr(4'd3, 8'hFF);
    #1 chk({4'b0, srq}, 8'h05, "R7 R10 srq back after end of service");
    rd(4'd0, rv); chk(rv, 8'h00, "R10 context closed");
    req_rx = 4'b0000;
    do_ack(4'hF);
    chk(ack_vec, 8'hA6, "R2 parallel served next");
    rd(4'd0, rv); chk(rv, 8'hA0, "R8 parallel context");
    wr(4'd3, 8'h00);

    set_req(4'b0100, 4'b0, 4'b0, 4'b0);
    rx_lvl[23:16] = 8'd7;
    rx_fifo_data = 8'h5A;
    do_ack(4'hF);
    chk(ack_vec, 8'hB4, "R4 receive ch2 vector");
    rd(4'd1, rv); chk(rv, 8'h07, "R9 receive level");
    rd(4'd5, rv); chk(rv, 8'h82, "R12 receive channel register");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cpu_rd = 1'b1; cpu_addr = 4'd2;
      #1 chk({7'b0, rx_pop}, 8'h01, "R9 pop pulse");
      chk({6'b0, rx_pop_ch}, 8'h02, "R9 pop channel");
      @(negedge clk); cpu_rd = 1'b0;
      chk(cpu_rdata, 8'h5A, "R9 receive data");
      #1 chk({7'b0, rx_pop}, 8'h00, "R9 pop ends");
    end
    wr(4'd3, 8'h00);
    req_rx = 4'b0;

    wr(4'd4, 8'h43);
    rd(4'd0, rv); chk(rv, 8'h93, "R11 software entry transmit ch3");
    rd(4'd6, rv); chk(rv, 8'h83, "R12 transmit channel register");
    rd(4'd5, rv); chk(rv, 8'h00, "R12 receive register idle in tx context");
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = 4'd2;
    #1 chk({7'b0, rx_pop}, 8'h00, "R9 no pop outside receive context");
    @(negedge clk); cpu_rd = 1'b0;
    chk(cpu_rdata, 8'h00, "R9 data reads zero outside receive context");
    wr(4'd4, 8'h02);
    rd(4'd0, rv); chk(rv, 8'h93, "R11 software write ignored while open");
    wr(4'd3, 8'h00);
    wr(4'd4, 8'hC1);
    rd(4'd7, rv); chk(rv, 8'h81, "R12 modem channel register");
    wr(4'd3, 8'h00);
    rd(4'd7, rv); chk(rv, 8'h00, "R12 modem register after close");

    rd(4'd9, rv); chk(rv, 8'h15, "R5 reset code ch1");
    wr(4'd9, 8'hEA);
    rd(4'd9, rv); chk(rv, 8'h0A, "R5 code written");
    set_req(4'b0010, 4'b0, 4'b0, 4'b0);
    do_ack(4'hF);
    chk(ack_vec, 8'h54, "R5 vector uses new code");
    wr(4'd3, 8'h00);
    set_req(4'b0, 4'b0, 4'b0, 4'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule